// File: doc/BRIEF.md
# Interrupt enable bank with pending latches

This block holds the enable state for 23 interrupt lines, numbered 32 to 54, behind a small memory-mapped register interface. Software turns lines on through a set-enable register and turns them off through a separate clear-enable register. In both registers only the bits written as 1 act, so one line can be changed without a read-modify-write. Either register reads back the current enable state. A register access takes effect only when the bus marks it as privileged.

On the interrupt side, every line has a pending latch. A raw request sets the latch whether or not the line is enabled. The latch holds until a per-line acknowledge clears it. The activation output offers a line to the downstream priority logic only while that line is both pending and enabled. A disabled line can therefore collect a request and stay silent. It is then offered as soon as software enables it.

Top module: `irq_enable_bank`

## Requirements
- R1: The set-enable register is at address 0x104 and the clear-enable register is at 0x184. In both, data bit n (n = 0..22) belongs to interrupt 32+n, which is line n of the irq vectors.
- R2: A privileged write to 0x104 enables every line whose data bit is 1 from the next cycle on. Data bits that are 0 leave their lines unchanged.
- R3: An enable bit goes to 0 only on a privileged write to 0x184 with that bit at 1. Bits written as 0 there are unchanged, and no write to 0x104 ever clears an enable.
- R4: A privileged read of 0x104 or 0x184 returns the enable vector in bits 22:0, with 1 meaning enabled. Bits 31:23 always read 0 and writes to them have no effect. Every other address reads 0.
- R5: While reset is asserted, and in the first cycle after it, all enables and all pending latches are 0.
- R6: When the privilege flag is 0, a write changes no state and a read returns 0.
- R7: A request on a line sets its pending latch in the next cycle whatever its enable state. The latch holds until an acknowledge on that line. When request and acknowledge arrive in the same cycle, the latch stays set.
- R8: `act_req` equals pending AND enable, bit by bit. A disabled line is never offered, whatever its pending state.
- R9: A line that became pending while disabled is offered in the cycle after a set-enable write for that line, with no new request needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_priv | input | 1 | 1 = privileged access |
| bus_rdata | output | 32 | Read data (combinational from address) |
| irq_req | input | 23 | Raw request per line |
| irq_ack | input | 23 | Acknowledge per line, clears pending |
| act_req | output | 23 | Lines pending and enabled |

## Verification
Single-bit set writes check the mapping from bit to line. All-ones writes to both addresses show that the reserved bits are inert and that a set write never clears. Requests that arrive while a line is disabled, followed later by its enable, separate the pending latch from the gating. Coincident request and acknowledge pin down which one wins. Unprivileged writes and reads, interleaved with privileged ones, show that the privilege flag gates both directions. A long random stretch mixes writes, reads, requests and acknowledges on all lines. Every cycle is compared against the reference model.

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int NUM_LINES = 23,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 12'h104,
  parameter logic [ADDR_W-1:0] CLR_OFS = 12'h184
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic [NUM_LINES-1:0] irq_ack,
  output logic [NUM_LINES-1:0] act_req
);

  logic [NUM_LINES-1:0] en_q, pend_q;
  logic hit_set, hit_clr, wr_set, wr_clr;

  assign hit_set = bus_addr == SET_OFS;
  assign hit_clr = bus_addr == CLR_OFS;
  assign wr_set  = bus_we && bus_priv && hit_set;
  assign wr_clr  = bus_we && bus_priv && hit_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_set)      en_q <= en_q | bus_wdata[NUM_LINES-1:0];
      else if (wr_clr) en_q <= en_q & ~bus_wdata[NUM_LINES-1:0];
      pend_q <= (pend_q & ~irq_ack) | irq_req;
    end
  end

  assign bus_rdata = (bus_priv && (hit_set || hit_clr)) ? DATA_W'(en_q) : '0;
  assign act_req   = pend_q & en_q;

  assert_set_no_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (($past(en_q) & ~en_q) == '0));

  assert_clear_only_by_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) & ~en_q) != '0 |-> $past(wr_clr));

  assert_reset_clean_R5: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && act_req == '0));

  assert_unpriv_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_priv) |=> $stable(en_q));

  assert_pending_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & ~irq_ack) & ~pend_q) == '0));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_LINES] == '0);

endmodule

// File: tb/tb_irq_enable_bank.sv
module tb_irq_enable_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 23;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, bus_priv = 0;
  logic [NL-1:0] irq_req = '0, irq_ack = '0, act_req;

  int total = 0, bad = 0;
  logic [NL-1:0] m_en = '0, m_pend = '0;

  irq_enable_bank dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] exp_rd();
    if (bus_priv && (bus_addr == 12'h104 || bus_addr == 12'h184)) return {9'b0, m_en};
    return '0;
  endfunction

  task automatic cyc(input string tag);
    #1;
    total++;
    if (bus_rdata !== exp_rd()) begin
      bad++;
      $display("FAIL %s rdata: actual=%h expected=%h", tag, bus_rdata, exp_rd());
    end
    total++;
    if (act_req !== (m_pend & m_en)) begin
      bad++;
      $display("FAIL %s act_req: actual=%h expected=%h", tag, act_req, m_pend & m_en);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_en = '0; m_pend = '0;
    end else begin
      if (bus_we && bus_priv && bus_addr == 12'h104) m_en = m_en | bus_wdata[NL-1:0];
      else if (bus_we && bus_priv && bus_addr == 12'h184) m_en = m_en & ~bus_wdata[NL-1:0];
      m_pend = (m_pend & ~irq_ack) | irq_req;
    end
    @(negedge clk);
    bus_we = 0; irq_req = '0; irq_ack = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p, input string tag);
    bus_addr = a; bus_wdata = d; bus_we = 1; bus_priv = p;
    cyc(tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic p, input string tag);
    bus_addr = a; bus_priv = p; bus_we = 0;
    cyc(tag);
  endtask

  initial begin
    @(negedge clk);
    cyc("R5 in reset"); cyc("R5 in reset");
    rst_n = 1;
    rd(12'h104, 1, "R5 after reset");
    // R1: bit 0 -> interrupt 32, bit 22 -> interrupt 54
    wr(12'h104, 32'h0000_0001, 1, "R1 set line32");
    rd(12'h104, 1, "R1 read set");
    wr(12'h104, 32'h0040_0000, 1, "R1 set line54");
    rd(12'h184, 1, "R1 read via clr addr");
    // R2: zero writes leave state
    wr(12'h104, 32'h0, 1, "R2 zero write");
    rd(12'h104, 1, "R2 unchanged");
    // R4: reserved bits
    wr(12'h104, 32'hFFFF_FFFF, 1, "R4 all ones");
    rd(12'h104, 1, "R4 reserved zero");
    rd(12'h100, 1, "R4 other addr");
    // R3
    wr(12'h184, 32'h0000_00F0, 1, "R3 clear some");
    rd(12'h104, 1, "R3 read");
    wr(12'h184, 32'h0, 1, "R3 zero clear");
    rd(12'h104, 1, "R3 unchanged");
    // R6
    wr(12'h184, 32'hFFFF_FFFF, 0, "R6 unpriv clear");
    rd(12'h104, 0, "R6 unpriv read");
    rd(12'h104, 1, "R6 state kept");
    wr(12'h184, 32'hFFFF_FFFF, 1, "R3 clear all");
    wr(12'h104, 32'h0000_0003, 0, "R6 unpriv set");
    rd(12'h104, 1, "R6 still off");
    // R7/R8: disabled pending
    irq_req = 23'h000010; cyc("R7 req disabled");
    cyc("R8 not offered");
    // R9
    wr(12'h104, 32'h0000_0010, 1, "R9 enable pending");
    cyc("R9 offered");
    irq_ack = 23'h000010; irq_req = 23'h000010; cyc("R7 req beats ack");
    cyc("R7 still pending");
    irq_ack = 23'h000010; cyc("R7 ack");
    cyc("R7 cleared");
    // random mix
    for (int i = 0; i < 400; i++) begin
      bus_addr = ($urandom % 3 == 0) ? 12'h184 : (($urandom % 2) ? 12'h104 : 12'h0A0);
      bus_wdata = $urandom;
      bus_we = $urandom % 2;
      bus_priv = ($urandom % 4) != 0;
      irq_req = NL'($urandom) & NL'($urandom);
      irq_ack = NL'($urandom) & NL'($urandom);
      cyc("R8 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule